// File: doc/BRIEF.md
# Dual-Mode Serial-to-Parallel FIFO Loader

This block sits behind a clock-recovery stage. That stage presents one recovered bit per strobe (`bit_en_i`, `bit_i`) in the system clock domain. The block assembles the bits into 16-bit words and writes them into an 18-bit-wide buffer FIFO through an active-low write strobe. While the line is idle, the first 1 is taken as a start bit. The frame length that follows depends on the mode sampled at that start bit. Command/reply frames carry 32 bits and yield two FIFO entries. Image frames carry 16 bits and yield one entry. In both modes the most significant bit arrives first.

The block respects the FIFO's full flag: a word that completes while the FIFO is full is discarded, and a sticky overflow indication is raised. A frame-sync output pulses once per completed frame. A link-valid output reports that at least one full frame has arrived and that bit strobes are still coming.

Top module: `s2p_fifo_loader`

## Requirements
- R1: While idle, bit strobes carrying 0 are ignored. The first strobe carrying 1 is the start bit and is not stored. No FIFO write happens without a complete word.
- R2: With `mode_i`=0 (image) latched at the start bit, the next 16 bits, MSB first, form one FIFO entry. The first bit received lands in bit 15.
- R3: With `mode_i`=1 (command/reply) latched at the start bit, the next 32 bits, MSB first, form two entries. Bits 31..16 are written first and bits 15..0 second.
- R4: FIFO data bits 17:16 are always written as 0. Bits 15:0 carry the word.
- R5: `fifo_wr_no` goes low for exactly one clock per accepted word. It goes low in the second clock after the clock that sampled the word's last bit strobe.
- R6: If `fifo_full_i` is high in the clock after a word's last bit was sampled, that word is not written and `overflow_o` rises. `overflow_o` stays high until reset.
- R7: `mode_i` is sampled only at the start bit. Changing it during a frame changes neither the frame length nor the data.
- R8: `frame_sync_o` is a one-clock pulse per completed frame. It occurs in the same clock as the strobe for the frame's final word, or in the clock where that strobe would occur if the word was dropped.
- R9: `link_ok_o` is low after reset and goes high with the first completed frame. It returns low once TIMEOUT clocks pass without a bit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | One-clock strobe: a recovered bit is present |
| bit_i | input | 1 | Recovered data bit |
| mode_i | input | 1 | Frame format: 1 command/reply (32 bits), 0 image (16 bits) |
| fifo_full_i | input | 1 | Buffer FIFO full flag |
| fifo_wr_no | output | 1 | Active-low FIFO write strobe |
| fifo_data_o | output | 18 | FIFO write data, bits 17:16 zero |
| overflow_o | output | 1 | Sticky: a word was dropped on full |
| frame_sync_o | output | 1 | One-clock pulse per completed frame |
| link_ok_o | output | 1 | Link valid indication |

## Verification
Image frames are driven with the words 0xA5C3, 0x8000, 0x0001, 0xFFFF and 0x0000. These separate the MSB-first ordering from a reversed shift, and they show that all-zero or all-one data bits are not mistaken for start bits. Command frames such as 0x12345678 and 0x80000001 show the word order and that the boundary between the two halves is correct. Leading idle zeros, a mode flip in the middle of a frame, and a frame sent while the FIFO is full show the start detection, the mode latching and the drop-with-sticky-flag behaviour. A long silence after traffic shows the link-valid timeout.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  typedef enum logic {
    MODE_IMAGE = 1'b0,
    MODE_CMD   = 1'b1
  } frame_mode_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_DATA = 1'b1
  } rx_state_e;
endpackage

// File: rtl/s2p_receiver.sv
module s2p_receiver
  import s2p_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              mode_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o,
  output logic              frame_done_o
);
  localparam int CNT_W = $clog2(2 * WORD_W);
  localparam int LOW_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IMG = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(2 * WORD_W - 1);

  rx_state_e         state_q;
  frame_mode_e       mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] sreg_q;
  logic              word_end, frame_end;

  assign word_end  = &cnt_q[LOW_W-1:0];
  assign frame_end = (mode_q == MODE_CMD) ? (cnt_q == LAST_CMD) : (cnt_q == LAST_IMG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= RX_IDLE;
      mode_q       <= MODE_IMAGE;
      cnt_q        <= '0;
      sreg_q       <= '0;
      word_vld_o   <= 1'b0;
      word_o       <= '0;
      frame_done_o <= 1'b0;
    end else begin
      word_vld_o   <= 1'b0;
      frame_done_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          // first 1 while idle is the start bit; mode latched only here
          if (bit_en_i && bit_i) begin
            state_q <= RX_DATA;
            mode_q  <= frame_mode_e'(mode_i);
            cnt_q   <= '0;
          end
        end
        RX_DATA: begin
          if (bit_en_i) begin
            sreg_q <= {sreg_q[WORD_W-3:0], bit_i};
            cnt_q  <= cnt_q + 1'b1;
            if (word_end) begin
              word_o     <= {sreg_q, bit_i};
              word_vld_o <= 1'b1;
            end
            if (frame_end) begin
              frame_done_o <= 1'b1;
              state_q      <= RX_IDLE;
            end
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/s2p_writer.sv
module s2p_writer #(
  parameter int WORD_W = 16,
  parameter int FIFO_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              frame_done_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_no,
  output logic [FIFO_W-1:0] fifo_data_o,
  output logic              overflow_o,
  output logic              frame_sync_o
);
  localparam int RSV_W = FIFO_W - WORD_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_wr_no   <= 1'b1;
      fifo_data_o  <= '0;
      overflow_o   <= 1'b0;
      frame_sync_o <= 1'b0;
    end else begin
      fifo_wr_no   <= 1'b1;
      frame_sync_o <= frame_done_i;
      if (word_vld_i) begin
        if (!fifo_full_i) begin
          fifo_wr_no  <= 1'b0;
          fifo_data_o <= {{RSV_W{1'b0}}, word_i};
        end else begin
          overflow_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/s2p_link_mon.sv
module s2p_link_mon #(
  parameter int TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic frame_done_i,
  output logic link_ok_o
);
  localparam int TO_W = $clog2(TIMEOUT + 1);
  localparam logic [TO_W-1:0] TO_MAX  = TO_W'(TIMEOUT);
  localparam logic [TO_W-1:0] TO_TRIP = TO_W'(TIMEOUT - 1);

  logic [TO_W-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q    <= '0;
      link_ok_o <= 1'b0;
    end else begin
      if (bit_en_i)             idle_q <= '0;
      else if (idle_q != TO_MAX) idle_q <= idle_q + 1'b1;

      if (frame_done_i)                     link_ok_o <= 1'b1;
      else if (!bit_en_i && idle_q == TO_TRIP) link_ok_o <= 1'b0;
    end
  end
endmodule

// File: rtl/s2p_fifo_loader.sv
module s2p_fifo_loader #(
  parameter int WORD_W  = 16,
  parameter int FIFO_W  = 18,
  parameter int TIMEOUT = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              mode_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_no,
  output logic [FIFO_W-1:0] fifo_data_o,
  output logic              overflow_o,
  output logic              frame_sync_o,
  output logic              link_ok_o
);
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              frame_done;

  s2p_receiver #(.WORD_W(WORD_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en_i),
    .bit_i        (bit_i),
    .mode_i       (mode_i),
    .word_vld_o   (word_vld),
    .word_o       (word),
    .frame_done_o (frame_done)
  );

  s2p_writer #(.WORD_W(WORD_W), .FIFO_W(FIFO_W)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_vld_i   (word_vld),
    .word_i       (word),
    .frame_done_i (frame_done),
    .fifo_full_i  (fifo_full_i),
    .fifo_wr_no   (fifo_wr_no),
    .fifo_data_o  (fifo_data_o),
    .overflow_o   (overflow_o),
    .frame_sync_o (frame_sync_o)
  );

  s2p_link_mon #(.TIMEOUT(TIMEOUT)) u_link (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en_i),
    .frame_done_i (frame_done),
    .link_ok_o    (link_ok_o)
  );
endmodule

// File: rtl/s2p_fifo_loader_chk.sv
module s2p_fifo_loader_chk #(
  parameter int RSV_W   = 2,
  parameter int TIMEOUT = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_en_i,
  input logic             fifo_full_i,
  input logic             fifo_wr_no,
  input logic [RSV_W-1:0] rsvd_i,
  input logic             overflow_o,
  input logic             frame_sync_o,
  input logic             link_ok_o
);
  localparam int CW = $clog2(TIMEOUT + 3);
  localparam logic [CW-1:0] C_MAX = CW'(TIMEOUT + 2);
  localparam logic [CW-1:0] C_LIM = CW'(TIMEOUT);

  logic [CW-1:0] quiet_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              quiet_q <= '0;
    else if (bit_en_i)        quiet_q <= '0;
    else if (quiet_q != C_MAX) quiet_q <= quiet_q + 1'b1;
  end

  p_strobe_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_wr_no |=> fifo_wr_no);
  p_rsvd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_wr_no |-> (rsvd_i == '0));
  p_no_write_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_wr_no |-> !$past(fifo_full_i));
  p_overflow_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  p_sync_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_o |=> !frame_sync_o);
  p_link_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_ok_o) |-> frame_sync_o);
  p_link_timeout_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q > C_LIM) |-> !link_ok_o);
endmodule

bind s2p_fifo_loader s2p_fifo_loader_chk #(.RSV_W(FIFO_W - WORD_W), .TIMEOUT(TIMEOUT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_en_i     (bit_en_i),
  .fifo_full_i  (fifo_full_i),
  .fifo_wr_no   (fifo_wr_no),
  .rsvd_i       (fifo_data_o[FIFO_W-1:WORD_W]),
  .overflow_o   (overflow_o),
  .frame_sync_o (frame_sync_o),
  .link_ok_o    (link_ok_o)
);

// File: tb/s2p_fifo_loader_tb.sv
`timescale 1ns/1ps
module s2p_fifo_loader_tb;
  localparam int TIMEOUT = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        bit_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        fifo_full_i = 1'b0;
  logic        fifo_wr_no;
  logic [17:0] fifo_data_o;
  logic        overflow_o, frame_sync_o, link_ok_o;

  int checks = 0, failures = 0, frames_done = 0, syncs = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  s2p_fifo_loader #(.TIMEOUT(TIMEOUT)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare every write
  always @(negedge clk_i) begin
    if (rst_ni && fifo_wr_no === 1'b0) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R1/R6 unexpected write actual=%0h expected=none", fifo_data_o);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check("R2/R3 word", {16'h0, fifo_data_o[15:0]}, {16'h0, e});
        check("R4 reserved", {30'h0, fifo_data_o[17:16]}, 32'h0);
      end
    end
    if (rst_ni && frame_sync_o === 1'b1) syncs++;
  end

  task automatic drive_bit(input logic b);
    @(posedge clk_i); #1 bit_en_i = 1'b1; bit_i = b;
    @(posedge clk_i); #1 bit_en_i = 1'b0; bit_i = 1'b0;
  endtask

  task automatic send_frame(input logic m, input logic [31:0] d, input bit flip, input bit lat);
    int n;
    n = m ? 32 : 16;
    if (!fifo_full_i) begin
      if (m) begin exp_q.push_back(d[31:16]); exp_q.push_back(d[15:0]); end
      else exp_q.push_back(d[15:0]);
    end
    mode_i = m;
    drive_bit(1'b1);
    if (flip) mode_i = ~m;
    for (int i = n - 1; i >= 0; i--) begin
      repeat (2) @(posedge clk_i);
      drive_bit(d[i]);
    end
    frames_done++;
    if (lat) begin
      check("R5 strobe not early", {31'h0, fifo_wr_no}, 32'h1);
      @(posedge clk_i); #1;
      check("R5 strobe latency", {31'h0, fifo_wr_no}, 32'h0);
      check("R8 sync with final strobe", {31'h0, frame_sync_o}, 32'h1);
    end
    repeat (5) @(posedge clk_i);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R5 reset strobe", {31'h0, fifo_wr_no}, 32'h1);
    check("R6 reset overflow", {31'h0, overflow_o}, 32'h0);
    check("R8 reset sync", {31'h0, frame_sync_o}, 32'h0);
    check("R9 reset link", {31'h0, link_ok_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);

    // R1: idle zeros are ignored
    for (int i = 0; i < 5; i++) drive_bit(1'b0);
    repeat (4) @(posedge clk_i); #1;
    check("R1 no write from idle zeros", exp_q.size(), 0);
    check("R9 link low before frame", {31'h0, link_ok_o}, 32'h0);

    send_frame(1'b0, 32'h0000_A5C3, 1'b0, 1'b1);   // R2
    check("R9 link after frame", {31'h0, link_ok_o}, 32'h1);
    send_frame(1'b0, 32'h0000_8000, 1'b0, 1'b0);
    send_frame(1'b0, 32'h0000_0001, 1'b0, 1'b0);
    send_frame(1'b0, 32'h0000_FFFF, 1'b0, 1'b0);
    send_frame(1'b0, 32'h0000_0000, 1'b0, 1'b0);
    send_frame(1'b1, 32'h1234_5678, 1'b0, 1'b1);   // R3
    send_frame(1'b1, 32'h8000_0001, 1'b0, 1'b0);
    send_frame(1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0);
    // R7: mode flips mid-frame
    send_frame(1'b0, 32'h0000_3C5A, 1'b1, 1'b0);
    send_frame(1'b1, 32'hCAFE_0F0F, 1'b1, 1'b0);
    check("R7 all words consumed", exp_q.size(), 0);
    check("R6 no overflow yet", {31'h0, overflow_o}, 32'h0);

    // R6: drop on full
    fifo_full_i = 1'b1;
    send_frame(1'b0, 32'h0000_1111, 1'b0, 1'b0);
    fifo_full_i = 1'b0;
    check("R6 overflow set", {31'h0, overflow_o}, 32'h1);
    send_frame(1'b0, 32'h0000_2222, 1'b0, 1'b0);
    check("R6 overflow sticky", {31'h0, overflow_o}, 32'h1);
    check("R6 queue drained", exp_q.size(), 0);
    check("R8 one sync per frame", syncs, frames_done);

    // R9 timeout
    repeat (TIMEOUT / 2) @(posedge clk_i); #1;
    check("R9 link held during short gap", {31'h0, link_ok_o}, 32'h1);
    repeat (TIMEOUT) @(posedge clk_i); #1;
    check("R9 link timeout", {31'h0, link_ok_o}, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule